// File: doc/BRIEF.md
# PCIe Configuration Window Base Decoder

This block holds the 64-bit base register of a memory-mapped PCIe configuration window. Firmware writes the register through ordinary configuration-space dword writes with byte enables. From the stored value the block decodes four results: whether the window is on, how large it is (256, 128 or 64 MB), where it starts, and whether the size code is the illegal one. It also reports where the 32-bit PCI memory hole begins. The hole sits directly above the window when the window is active, and otherwise starts at the default window base. The hole always ends one byte below the fixed I/O interrupt controller address.

A combinational lookup port takes a memory address and reports whether it falls inside the active window. On a hit it splits the window offset into bus, device, function and register-offset fields for a later stage that issues the configuration transaction. Register bytes are written on one clock edge, and the decoded window follows on the next edge.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the register holds 0x00000000_B0000001, the window is enabled with size code 0 (256 MB), its base is 0xB0000000, the hole starts at 0xC0000000, and the hole end output reads 0xFEBFFFFF.
- R2: A write with `cfgWrEn`=1 to dword index REG_OFS/4 loads register bytes 0..3 from the data lanes whose byte enables are set. A write to index REG_OFS/4+1 loads bytes 4..7 in the same way. Lanes without an enable, other dword indexes, and cycles with `cfgWrEn`=0 leave the register unchanged.
- R3: The decoded outputs (enable, size code, error flag, base, hole start) take up a register change one clock edge after the register itself changes.
- R4: Register bits [2:1] are the size code: 0 selects 256 MB, 1 selects 128 MB and 2 selects 64 MB. The base is the register value with only bits [38:28], [38:27] or [38:26] kept for these three sizes. All other base bits are zero.
- R5: Size code 3 is reserved. It raises `winErr`, no address hits, and the hole starts at the default base 0xB0000000.
- R6: Register bit 0 is the enable. When it is 0, no address hits and the hole starts at 0xB0000000.
- R7: With the window enabled and a legal size code, the hole starts at base plus window length. The hole end output is the I/O interrupt controller address 0xFEC00000 minus 1 in every state.
- R8: `reqHit` is 1 exactly when the window is active and base <= `reqAddr` < base + length. The addresses base-1 and base+length miss.
- R9: On a hit, with offset = `reqAddr` - base, the bus is offset[27:20] limited to the window's bus count (256, 128 or 64). The device is offset[19:15], the function is offset[14:12] and the register offset is offset[11:0]. On a miss all four fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrDw | input | 6 | Dword index of the configuration write |
| cfgWrBe | input | 4 | Byte enables of the write |
| cfgWrData | input | 32 | Write data |
| regValue | output | 64 | Current base register contents |
| winEnable | output | 1 | Decoded enable bit |
| winErr | output | 1 | Reserved size code in use |
| winLenCode | output | 2 | Decoded size code |
| winBase | output | ADDR_W | Masked window base |
| holeStart | output | ADDR_W | First address of the PCI hole |
| holeLast | output | ADDR_W | Last address of the PCI hole |
| reqAddr | input | ADDR_W | Address to look up |
| reqHit | output | 1 | Address lies in the active window |
| reqBus | output | 8 | Bus number of the hit |
| reqDev | output | 5 | Device number of the hit |
| reqFunc | output | 3 | Function number of the hit |
| reqReg | output | 12 | Register offset of the hit |

## Verification
Several rules are checked by assertions on every cycle. The decoded enable lags the register by exactly one edge. The register holds still when no write is strobed. The base has no bits below 26. A hit never occurs when the window is disabled or in error, a hit always lies between the base and the hole start, and the lookup fields are zero on a miss. Other properties can only be shown by the bench scenarios, which sweep every size code, both enable values and several base patterns with junk in the masked-off bits. These cover the exact masked base for each size, the hole start arithmetic, the first and last addresses of each window, the bus limiting in the smaller windows, and the per-lane byte loading.

// File: rtl/cfgwin_pkg.sv
`timescale 1ns/1ps
package cfgwin_pkg;

  // the window base register is a fixed 64-bit quantity
  localparam int unsigned REG_BYTES = 8;
  localparam int unsigned LANES     = 4;

  typedef enum logic [1:0] {
    LEN_256M = 2'b00,
    LEN_128M = 2'b01,
    LEN_64M  = 2'b10,
    LEN_RSVD = 2'b11
  } winLen_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic [REG_BYTES-1:0] byteLd;
    logic                 refresh;
  } winStrobe_t;

endpackage

// File: rtl/cfgwin_ctrl.sv
`timescale 1ns/1ps
module cfgwin_ctrl
  import cfgwin_pkg::*;
#(
  parameter int unsigned REG_OFS = 8'h60
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [5:0]       cfgWrDw,
  input  logic [LANES-1:0] cfgWrBe,
  output winStrobe_t       strobe
);

  localparam int unsigned HALVES = REG_BYTES / LANES;
  localparam logic [5:0]  BASE_DW = 6'(REG_OFS >> 2);

  logic [REG_BYTES-1:0] byteLd;
  logic                 refreshPend;

  // each dword half of the register owns one group of byte-load strobes
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic hit;
    assign hit = cfgWrEn && (cfgWrDw == BASE_DW + 6'(h));
    assign byteLd[h*LANES +: LANES] = hit ? cfgWrBe : '0;
  end

  // any byte landing in the register schedules a decode refresh next cycle
  always_ff @(posedge clk) begin
    if (!rstN) refreshPend <= 1'b0;
    else       refreshPend <= |byteLd;
  end

  assign strobe.byteLd  = byteLd;
  assign strobe.refresh = refreshPend;

endmodule

// File: rtl/cfgwin_dp.sv
`timescale 1ns/1ps
module cfgwin_dp
  import cfgwin_pkg::*;
#(
  parameter int unsigned          ADDR_W      = 40,
  parameter int unsigned          MAX_SHIFT   = 28,
  parameter logic [ADDR_W-1:0]    DEF_BASE    = 'hB000_0000,
  parameter logic [ADDR_W-1:0]    IOAPIC_ADDR = 'hFEC0_0000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  winStrobe_t             strobe,
  input  logic [31:0]            cfgWrData,
  input  logic [ADDR_W-1:0]      reqAddr,
  output logic [63:0]            regValue,
  output logic                   winEnable,
  output logic                   winErr,
  output logic [1:0]             winLenCode,
  output logic [ADDR_W-1:0]      winBase,
  output logic [ADDR_W-1:0]      holeStart,
  output logic [ADDR_W-1:0]      holeLast,
  output logic                   reqHit,
  output logic [7:0]             reqBus,
  output logic [4:0]             reqDev,
  output logic [2:0]             reqFunc,
  output logic [11:0]            reqReg
);

  localparam int unsigned BASE_HI = ADDR_W - 2;
  localparam int unsigned BUS_LSB = MAX_SHIFT - 8;
  localparam int unsigned DEV_LSB = BUS_LSB - 5;
  localparam int unsigned FN_LSB  = DEV_LSB - 3;
  localparam logic [63:0] DEF_REG = 64'(DEF_BASE) | 64'h1;

  typedef struct packed {
    logic              en;
    logic              err;
    logic [1:0]        code;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [ADDR_W-1:0] hole;
  } decode_t;

  function automatic decode_t calcDecode(input logic [63:0] r);
    decode_t d;
    int lowBit;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] span;
    d.en   = r[0];
    d.code = r[2:1];
    d.err  = (winLen_e'(r[2:1]) == LEN_RSVD);
    lowBit = d.err ? int'(MAX_SHIFT) : int'(MAX_SHIFT) - int'(r[2:1]);
    span   = '0;
    for (int i = 0; i < int'(ADDR_W); i++) begin
      mask[i] = (i >= lowBit) && (i <= int'(BASE_HI));
      if (i == lowBit) span[i] = 1'b1;
    end
    d.base  = r[ADDR_W-1:0] & mask;
    d.limit = d.base + span;
    d.hole  = (d.en && !d.err) ? d.limit : DEF_BASE;
    return d;
  endfunction

  logic [63:0] regQ;
  decode_t     decQ;

  // byte-granular register storage
  for (genvar b = 0; b < int'(REG_BYTES); b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN)                 regQ[b*8 +: 8] <= DEF_REG[b*8 +: 8];
      else if (strobe.byteLd[b]) regQ[b*8 +: 8] <= cfgWrData[(b % LANES)*8 +: 8];
    end
  end

  // decode stage, refreshed one cycle after the register moves
  always_ff @(posedge clk) begin
    if (!rstN)               decQ <= calcDecode(DEF_REG);
    else if (strobe.refresh) decQ <= calcDecode(regQ);
  end

  // lookup against the decoded window
  logic              active;
  logic              inWin;
  logic [ADDR_W-1:0] offs;
  logic [7:0]        busMask;

  always_comb begin
    unique case (winLen_e'(decQ.code))
      LEN_128M: busMask = 8'h7F;
      LEN_64M:  busMask = 8'h3F;
      default:  busMask = 8'hFF;
    endcase
  end

  assign active = decQ.en && !decQ.err;
  assign inWin  = active && (reqAddr >= decQ.base) && (reqAddr < decQ.limit);
  assign offs   = reqAddr - decQ.base;

  assign reqHit  = inWin;
  assign reqBus  = inWin ? (offs[BUS_LSB +: 8] & busMask) : '0;
  assign reqDev  = inWin ? offs[DEV_LSB +: 5] : '0;
  assign reqFunc = inWin ? offs[FN_LSB +: 3]  : '0;
  assign reqReg  = inWin ? offs[FN_LSB-1:0]   : '0;

  assign regValue   = regQ;
  assign winEnable  = decQ.en;
  assign winErr     = decQ.err;
  assign winLenCode = decQ.code;
  assign winBase    = decQ.base;
  assign holeStart  = decQ.hole;
  assign holeLast   = IOAPIC_ADDR - 1'b1;

endmodule

// File: rtl/cfgwin_decoder.sv
`timescale 1ns/1ps
module cfgwin_decoder
  import cfgwin_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 40,
  parameter int unsigned       MAX_SHIFT   = 28,
  parameter int unsigned       REG_OFS     = 8'h60,
  parameter logic [ADDR_W-1:0] DEF_BASE    = 'hB000_0000,
  parameter logic [ADDR_W-1:0] IOAPIC_ADDR = 'hFEC0_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [5:0]        cfgWrDw,
  input  logic [3:0]        cfgWrBe,
  input  logic [31:0]       cfgWrData,
  output logic [63:0]       regValue,
  output logic              winEnable,
  output logic              winErr,
  output logic [1:0]        winLenCode,
  output logic [ADDR_W-1:0] winBase,
  output logic [ADDR_W-1:0] holeStart,
  output logic [ADDR_W-1:0] holeLast,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqHit,
  output logic [7:0]        reqBus,
  output logic [4:0]        reqDev,
  output logic [2:0]        reqFunc,
  output logic [11:0]       reqReg
);

  winStrobe_t strobe;

  cfgwin_ctrl #(.REG_OFS(REG_OFS)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWrEn (cfgWrEn),
    .cfgWrDw (cfgWrDw),
    .cfgWrBe (cfgWrBe),
    .strobe  (strobe)
  );

  cfgwin_dp #(
    .ADDR_W      (ADDR_W),
    .MAX_SHIFT   (MAX_SHIFT),
    .DEF_BASE    (DEF_BASE),
    .IOAPIC_ADDR (IOAPIC_ADDR)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgWrData  (cfgWrData),
    .reqAddr    (reqAddr),
    .regValue   (regValue),
    .winEnable  (winEnable),
    .winErr     (winErr),
    .winLenCode (winLenCode),
    .winBase    (winBase),
    .holeStart  (holeStart),
    .holeLast   (holeLast),
    .reqHit     (reqHit),
    .reqBus     (reqBus),
    .reqDev     (reqDev),
    .reqFunc    (reqFunc),
    .reqReg     (reqReg)
  );

endmodule

// File: rtl/cfgwin_decoder_chk.sv
`timescale 1ns/1ps
module cfgwin_decoder_chk #(
  parameter int unsigned ADDR_W = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [63:0]       regValue,
  input logic              winEnable,
  input logic              winErr,
  input logic [ADDR_W-1:0] winBase,
  input logic [ADDR_W-1:0] holeStart,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqHit,
  input logic [7:0]        reqBus,
  input logic [4:0]        reqDev,
  input logic [2:0]        reqFunc,
  input logic [11:0]       reqReg
);

  // R2: register moves only on a strobed write
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(regValue));

  // R3: decoded enable trails the register by one edge
  a_r3_decode_lag: assert property (@(posedge clk) disable iff (!rstN)
    winEnable == $past(regValue[0]));

  // R4: no base bits below the smallest window alignment
  a_r4_base_align: assert property (@(posedge clk) disable iff (!rstN)
    winBase[25:0] == '0);

  // R5: reserved size never hits
  a_r5_err_nohit: assert property (@(posedge clk) disable iff (!rstN)
    winErr |-> !reqHit);

  // R6: disabled window never hits
  a_r6_off_nohit: assert property (@(posedge clk) disable iff (!rstN)
    !winEnable |-> !reqHit);

  // R8: hit lies between base and the hole start
  a_r8_hit_bounds: assert property (@(posedge clk) disable iff (!rstN)
    reqHit |-> (reqAddr >= winBase) && (reqAddr < holeStart));

  // R9: fields are quiet on a miss
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    !reqHit |-> (reqBus == '0) && (reqDev == '0) && (reqFunc == '0) && (reqReg == '0));

endmodule

bind cfgwin_decoder cfgwin_decoder_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_cfgwin_decoder.sv
`timescale 1ns/1ps
module test_cfgwin_decoder;

  localparam int unsigned ADDR_W = 40;
  localparam logic [5:0]  LO_DW  = 6'h18;
  localparam logic [5:0]  HI_DW  = 6'h19;
  localparam logic [ADDR_W-1:0] DEF_B = 40'hB000_0000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic [5:0]        cfgWrDw = '0;
  logic [3:0]        cfgWrBe = '0;
  logic [31:0]       cfgWrData = '0;
  logic [63:0]       regValue;
  logic              winEnable, winErr;
  logic [1:0]        winLenCode;
  logic [ADDR_W-1:0] winBase, holeStart, holeLast;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqHit;
  logic [7:0]        reqBus;
  logic [4:0]        reqDev;
  logic [2:0]        reqFunc;
  logic [11:0]       reqReg;

  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  cfgwin_decoder i_cfgwin_decoder (.*);

  task automatic chkEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeDw(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrDw = dw; cfgWrBe = be; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic writeReg(input logic [63:0] v);
    writeDw(LO_DW, 4'hF, v[31:0]);
    writeDw(HI_DW, 4'hF, v[63:32]);
    @(negedge clk);
  endtask

  task automatic probe(input logic [ADDR_W-1:0] a, input logic expHit,
                       input logic [ADDR_W-1:0] base, input string tag);
    logic [ADDR_W-1:0] off;
    reqAddr = a;
    #1;
    off = a - base;
    chkEq({"R8 hit ", tag}, 64'(reqHit), 64'(expHit));
    chkEq({"R9 bus ", tag}, 64'(reqBus), expHit ? 64'(off[27:20]) : 64'h0);
    chkEq({"R9 dev ", tag}, 64'(reqDev), expHit ? 64'(off[19:15]) : 64'h0);
    chkEq({"R9 fn ",  tag}, 64'(reqFunc), expHit ? 64'(off[14:12]) : 64'h0);
    chkEq({"R9 reg ", tag}, 64'(reqReg), expHit ? 64'(off[11:0]) : 64'h0);
  endtask

  initial begin
    #(200000 * 5);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    logic [63:0] seeds [4];
    seeds[0] = 64'h0000_0000_B000_0000;
    seeds[1] = 64'hFFFF_FFFF_FFFF_FFF8;
    seeds[2] = 64'h0000_0000_0FFF_FFF0;
    seeds[3] = 64'h1234_5600_0000_0000;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    chkEq("R1 reg", regValue, 64'h0000_0000_B000_0001);
    chkEq("R1 enable", 64'(winEnable), 64'h1);
    chkEq("R1 code", 64'(winLenCode), 64'h0);
    chkEq("R1 base", 64'(winBase), 64'hB000_0000);
    chkEq("R1 hole", 64'(holeStart), 64'hC000_0000);
    chkEq("R7 hole end", 64'(holeLast), 64'hFEBF_FFFF);

    // R2 byte lanes and ignored writes
    writeDw(LO_DW, 4'b0101, 32'hA1B2_C3D5);
    @(negedge clk);
    chkEq("R2 low lanes 0,2", regValue, 64'h0000_0000_B0B2_00D5);
    writeDw(HI_DW, 4'b1000, 32'h7700_0000);
    @(negedge clk);
    chkEq("R2 lane 7", regValue, 64'h7700_0000_B0B2_00D5);
    writeDw(6'h1A, 4'hF, 32'hFFFF_FFFF);
    @(negedge clk);
    chkEq("R2 other dword ignored", regValue, 64'h7700_0000_B0B2_00D5);
    @(negedge clk);
    cfgWrDw = LO_DW; cfgWrBe = 4'hF; cfgWrData = 32'h0; cfgWrEn = 1'b0;
    @(negedge clk);
    chkEq("R2 no strobe ignored", regValue, 64'h7700_0000_B0B2_00D5);
    writeDw(LO_DW, 4'b0000, 32'h0);
    @(negedge clk);
    chkEq("R2 no lanes ignored", regValue, 64'h7700_0000_B0B2_00D5);

    // R3 decode lags by one edge
    writeReg(64'h0000_0000_B000_0001);
    writeDw(LO_DW, 4'hF, 32'h4000_0005);
    chkEq("R3 reg now", regValue, 64'h0000_0000_4000_0005);
    chkEq("R3 base still old", 64'(winBase), 64'hB000_0000);
    @(negedge clk);
    chkEq("R3 base updated", 64'(winBase), 64'h4000_0000);
    chkEq("R3 code updated", 64'(winLenCode), 64'h2);

    // sweep of seeds, size codes and enable
    for (int s = 0; s < 4; s++) begin
      for (int code = 0; code < 4; code++) begin
        for (int en = 0; en < 2; en++) begin
          logic [63:0] v;
          logic [ADDR_W-1:0] lenB, mask, expBase, expHole, inner;
          logic act;
          string tag;
          v = (seeds[s] & ~64'h7) | 64'(code << 1) | 64'(en);
          writeReg(v);
          tag = $sformatf("s%0d c%0d e%0d", s, code, en);
          lenB = (code == 3) ? 40'h1000_0000 : (40'h1000_0000 >> code);
          mask = ((40'h1 << 39) - 40'h1) & ~(lenB - 40'h1);
          expBase = v[ADDR_W-1:0] & mask;
          act = (en == 1) && (code != 3);
          expHole = act ? expBase + lenB : DEF_B;
          chkEq({"R4 base ", tag}, 64'(winBase), 64'(expBase));
          chkEq({"R4 code ", tag}, 64'(winLenCode), 64'(code));
          chkEq({"R5 err ", tag}, 64'(winErr), 64'(code == 3));
          chkEq({"R6 enable ", tag}, 64'(winEnable), 64'(en));
          chkEq({"R7 hole ", tag}, 64'(holeStart), 64'(expHole));
          chkEq({"R7 hole end ", tag}, 64'(holeLast), 64'hFEBF_FFFF);
          if (expBase != '0) probe(expBase - 40'h1, 1'b0, expBase, {"below ", tag});
          probe(expBase, act, expBase, {"first ", tag});
          probe(expBase + lenB - 40'h1, act, expBase, {"last ", tag});
          probe(expBase + lenB, 1'b0, expBase, {"past ", tag});
          inner = 40'h0E59_DABC & (lenB - 40'h1);
          probe(expBase + inner, act, expBase, {"inner ", tag});
        end
      end
    end

    // R9 bus limiting in the 64 MB window
    writeReg(64'h0000_0000_8000_0005);
    probe(40'h8000_0000 + 40'h03F0_0000, 1'b1, 40'h8000_0000, "R9 top bus 64M");
    chkEq("R9 bus 63", 64'(reqBus), 64'h3F);

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule